// File: doc/BRIEF.md
# Product-Term Distribution Network

This block routes the outputs of one logic block's local AND array to its macrocells. Each macrocell owns a programmable select mask over the whole product-term vector. Its output is the OR of every product term that its mask selects. One product term may feed several macrocells, but only when all of those macrocells sit in the same aligned group of four.

Configuration goes through a parallel write port that is open only while `cfg_en_i` is high. While the port is open, every macrocell output is held low. A mask that selects more terms than the per-macrocell cap is refused, and an error flag is raised. A separate flag shows whether the stored masks share any term across group boundaries.

Each output is formed by a full-width AND followed by an OR reduction over all terms. The logic depth is therefore the same whatever masks are stored.

Top module: `pta_top`

## Requirements
- R1: While `rst_ni` is low, all stored masks are cleared, `sum_o` is all zero and both error flags are low.
- R2: With `cfg_en_i` low, `sum_o[m]` is the OR of the `pt_i` bits whose positions are set in macrocell m's stored mask; mask bit j selects `pt_i[j]`.
- R3: A macrocell whose stored mask is empty drives 0 for every `pt_i` pattern.
- R4: With `cfg_en_i` and `cfg_we_i` high at a rising edge, a mask with at most 16 bits set (16 included) is stored at macrocell `cfg_addr_i`, and `range_err_o` is low after that edge.
- R5: A write whose mask has more than 16 bits set leaves the stored mask unchanged and sets `range_err_o` after that edge. The flag stays set until the next accepted write or reset.
- R6: When `cfg_en_i` is low, `cfg_we_i` has no effect on any stored mask or on `range_err_o`.
- R7: While `cfg_en_i` is high, `sum_o` is all zero, whatever `pt_i` holds.
- R8: `share_err_o` is high exactly when some product term is selected by stored masks of macrocells in two different groups, where group = macrocell index / 4. A term shared within one group raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pt_i | input | 80 | Product-term results from the AND array |
| cfg_en_i | input | 1 | Configuration window open; outputs forced low |
| cfg_we_i | input | 1 | Write strobe for the mask |
| cfg_addr_i | input | 4 | Target macrocell index |
| cfg_mask_i | input | 80 | Select mask to be written |
| sum_o | output | 16 | Per-macrocell OR-sum |
| range_err_o | output | 1 | Last write refused for exceeding the term cap |
| share_err_o | output | 1 | Stored masks share a term across groups |

## Verification
The hardest state to reach from the ports is one where the masks are legal one by one but overlap across a group boundary, while a refused mask sits between two accepted ones. The stimulus table builds up this state in steps. It first writes masks that share term 0 inside group 0. It then writes a mask with exactly 17 bits, and later a group-3 mask that reuses terms already held by groups 0 and 2. Between these writes it applies product-term patterns, so that both the refused mask and the cleared conflict can be seen at `sum_o` and `share_err_o`.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int unsigned NUM_MC_D = 16;
  localparam int unsigned NUM_PT_D = 80;
  localparam int unsigned MAX_PT_D = 16;
  localparam int unsigned GRP_D    = 4;
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store #(
  parameter int unsigned NUM_MC = pta_pkg::NUM_MC_D,
  parameter int unsigned NUM_PT = pta_pkg::NUM_PT_D,
  parameter int unsigned MAX_PT = pta_pkg::MAX_PT_D,
  parameter int unsigned AW     = $clog2(NUM_MC)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_en_i,
  input  logic                           cfg_we_i,
  input  logic [AW-1:0]                  cfg_addr_i,
  input  logic [NUM_PT-1:0]              cfg_mask_i,
  output logic [NUM_MC-1:0][NUM_PT-1:0]  mask_o,
  output logic                           range_err_o
);
  logic [NUM_MC-1:0][NUM_PT-1:0] mask_q;
  logic                          err_q;
  logic                          wr;
  logic                          fits;

  assign wr   = cfg_en_i && cfg_we_i && (32'(cfg_addr_i) < NUM_MC);
  assign fits = ($countones(cfg_mask_i) <= MAX_PT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else if (wr) begin
      if (fits) mask_q[cfg_addr_i] <= cfg_mask_i;
      err_q <= !fits;
    end
  end

  assign mask_o      = mask_q;
  assign range_err_o = err_q;
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
  parameter int unsigned NUM_MC = pta_pkg::NUM_MC_D,
  parameter int unsigned NUM_PT = pta_pkg::NUM_PT_D
) (
  input  logic [NUM_PT-1:0]              pt_i,
  input  logic [NUM_MC-1:0][NUM_PT-1:0]  mask_i,
  input  logic                           quiet_i,
  output logic [NUM_MC-1:0]              sum_o
);
  // fixed AND+OR depth per macrocell regardless of mask contents
  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    assign sum_o[m] = !quiet_i && (|(pt_i & mask_i[m]));
  end
endmodule

// File: rtl/pta_share_check.sv
module pta_share_check #(
  parameter int unsigned NUM_MC = pta_pkg::NUM_MC_D,
  parameter int unsigned NUM_PT = pta_pkg::NUM_PT_D,
  parameter int unsigned GRP    = pta_pkg::GRP_D
) (
  input  logic [NUM_MC-1:0][NUM_PT-1:0] mask_i,
  output logic                          share_err_o
);
  localparam int unsigned NGRP = (NUM_MC + GRP - 1) / GRP;

  logic [NGRP-1:0][NUM_PT-1:0] grp_use;
  logic [NUM_PT-1:0]           clash;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      grp_use[g] = '0;
      for (int k = 0; k < int'(GRP); k++) begin
        if (g * GRP + k < NUM_MC) grp_use[g] = grp_use[g] | mask_i[g*GRP+k];
      end
    end
  end

  for (genvar j = 0; j < NUM_PT; j++) begin : g_pt
    logic [NGRP-1:0] col;
    for (genvar g = 0; g < NGRP; g++) begin : g_col
      assign col[g] = grp_use[g][j];
    end
    assign clash[j] = !$onehot0(col);
  end

  assign share_err_o = |clash;
endmodule

// File: rtl/pta_top.sv
module pta_top #(
  parameter int unsigned NUM_MC = pta_pkg::NUM_MC_D,
  parameter int unsigned NUM_PT = pta_pkg::NUM_PT_D,
  parameter int unsigned MAX_PT = pta_pkg::MAX_PT_D,
  parameter int unsigned GRP    = pta_pkg::GRP_D,
  parameter int unsigned AW     = $clog2(NUM_MC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PT-1:0] pt_i,
  input  logic              cfg_en_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [NUM_PT-1:0] cfg_mask_i,
  output logic [NUM_MC-1:0] sum_o,
  output logic              range_err_o,
  output logic              share_err_o
);
  logic [NUM_MC-1:0][NUM_PT-1:0] mask_q;

  pta_cfg_store #(.NUM_MC(NUM_MC), .NUM_PT(NUM_PT), .MAX_PT(MAX_PT), .AW(AW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_en_i    (cfg_en_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_mask_i  (cfg_mask_i),
    .mask_o      (mask_q),
    .range_err_o (range_err_o)
  );

  pta_or_plane #(.NUM_MC(NUM_MC), .NUM_PT(NUM_PT)) u_plane (
    .pt_i    (pt_i),
    .mask_i  (mask_q),
    .quiet_i (cfg_en_i),
    .sum_o   (sum_o)
  );

  pta_share_check #(.NUM_MC(NUM_MC), .NUM_PT(NUM_PT), .GRP(GRP)) u_share (
    .mask_i      (mask_q),
    .share_err_o (share_err_o)
  );
endmodule

// File: rtl/pta_checker.sv
module pta_checker #(
  parameter int unsigned NUM_MC = pta_pkg::NUM_MC_D,
  parameter int unsigned NUM_PT = pta_pkg::NUM_PT_D,
  parameter int unsigned MAX_PT = pta_pkg::MAX_PT_D,
  parameter int unsigned AW     = $clog2(NUM_MC)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cfg_en_i,
  input logic                          cfg_we_i,
  input logic [AW-1:0]                 cfg_addr_i,
  input logic [NUM_PT-1:0]             cfg_mask_i,
  input logic [NUM_MC-1:0][NUM_PT-1:0] mask_q,
  input logic [NUM_MC-1:0]             sum_o,
  input logic                          range_err_o
);
  a_r7_quiet_in_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> sum_o == '0);

  a_r5_reject_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && cfg_we_i && $countones(cfg_mask_i) > MAX_PT) |=> range_err_o);

  a_r5_reject_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && cfg_we_i && $countones(cfg_mask_i) > MAX_PT) |=> $stable(mask_q));

  a_r4_accept_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && cfg_we_i && $countones(cfg_mask_i) <= MAX_PT && 32'(cfg_addr_i) < NUM_MC)
    |=> (!range_err_o && mask_q[$past(cfg_addr_i)] == $past(cfg_mask_i)));

  a_r6_closed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> ($stable(mask_q) && $stable(range_err_o)));

  for (genvar m = 0; m < NUM_MC; m++) begin : g_empty
    a_r3_empty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q[m] == '0) |-> !sum_o[m]);
  end
endmodule

bind pta_top pta_checker #(.NUM_MC(NUM_MC), .NUM_PT(NUM_PT), .MAX_PT(MAX_PT), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_en_i    (cfg_en_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_mask_i  (cfg_mask_i),
  .mask_q      (mask_q),
  .sum_o       (sum_o),
  .range_err_o (range_err_o)
);

// File: tb/sim_pta_top.sv
module sim_pta_top;
  localparam int NMC = 16;
  localparam int NPT = 80;
  localparam int CAP = 16;
  localparam int NROW = 17;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NPT-1:0] pt_i = '0;
  logic           cfg_en_i = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic [3:0]     cfg_addr_i = '0;
  logic [NPT-1:0] cfg_mask_i = '0;
  logic [NMC-1:0] sum_o;
  logic           range_err_o;
  logic           share_err_o;

  always #10 clk_i = ~clk_i;

  pta_top u0 (.*);

  // row: {en, we, addr[3:0], mask[79:0], pt[79:0]}
  localparam logic [165:0] ROWS [NROW] = '{
    {1'b1, 1'b1, 4'd0,  80'h0000_0000_0000_0000_000F, 80'h0},
    {1'b1, 1'b1, 4'd1,  80'h0000_0000_0000_0000_0FF0, 80'h0},
    {1'b1, 1'b1, 4'd5,  80'h0000_0000_0000_FFFF_0000, 80'h0},
    {1'b1, 1'b1, 4'd6,  80'h0000_0000_0000_0001_FFFF, 80'h0},
    {1'b1, 1'b1, 4'd2,  80'h0000_0000_0000_0000_0001, 80'h0},
    {1'b0, 1'b0, 4'd0,  80'h0,                        80'h0000_0000_0000_0000_0001},
    {1'b0, 1'b0, 4'd0,  80'h0,                        80'h0000_0000_0000_0000_0010},
    {1'b0, 1'b0, 4'd0,  80'h0,                        80'h0000_0000_0000_0001_0000},
    {1'b0, 1'b0, 4'd0,  80'h0,                        {80{1'b1}}},
    {1'b0, 1'b1, 4'd3,  80'h0000_0000_0000_0000_0001, 80'h0000_0000_0000_0000_0001},
    {1'b1, 1'b0, 4'd0,  80'h0,                        {80{1'b1}}},
    {1'b1, 1'b1, 4'd8,  80'h8000_0000_0000_0000_0000, {80{1'b1}}},
    {1'b0, 1'b0, 4'd0,  80'h0,                        80'h8000_0000_0000_0000_0000},
    {1'b1, 1'b1, 4'd12, 80'h8000_0000_0000_0000_0001, 80'h0},
    {1'b0, 1'b0, 4'd0,  80'h0,                        {80{1'b1}}},
    {1'b1, 1'b1, 4'd12, 80'h0,                        80'h0},
    {1'b0, 1'b0, 4'd0,  80'h0,                        {80{1'b1}}}
  };

  logic [NPT-1:0] mdl_mask [NMC];
  logic           mdl_err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [NMC-1:0] exp_sum(input logic en, input logic [NPT-1:0] pt);
    logic [NMC-1:0] s = '0;
    for (int m = 0; m < NMC; m++) s[m] = !en && ((pt & mdl_mask[m]) != '0);
    return s;
  endfunction

  function automatic logic exp_share();
    for (int j = 0; j < NPT; j++) begin
      int grps = 0;
      for (int g = 0; g < NMC / 4; g++) begin
        logic hit = 1'b0;
        for (int k = 0; k < 4; k++) hit |= mdl_mask[g*4+k][j];
        if (hit) grps++;
      end
      if (grps > 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int m = 0; m < NMC; m++) mdl_mask[m] = '0;
    mdl_err = 1'b0;
    // R1: in reset, with pt all ones
    pt_i = '1;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1 sum in reset", 32'(sum_o), 32'h0);
    check("R1 range_err in reset", 32'(range_err_o), 32'h0);
    check("R1 share_err in reset", 32'(share_err_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 R3 sum after reset", 32'(sum_o), 32'h0);

    for (int r = 0; r < NROW; r++) begin
      logic [165:0] row = ROWS[r];
      cfg_en_i   = row[165];
      cfg_we_i   = row[164];
      cfg_addr_i = row[163:160];
      cfg_mask_i = row[159:80];
      pt_i       = row[79:0];
      if (row[165] && row[164]) begin
        if ($countones(row[159:80]) <= CAP) begin
          mdl_mask[row[163:160]] = row[159:80];
          mdl_err = 1'b0;
        end else mdl_err = 1'b1;
      end
      @(posedge clk_i);
      #5;
      check("R2/R3/R6/R7 sum", 32'(sum_o), 32'(exp_sum(row[165], row[79:0])));
      check("R4/R5/R6 range_err", 32'(range_err_o), 32'(mdl_err));
      check("R8 share_err", 32'(share_err_o), 32'(exp_share()));
      @(negedge clk_i);
    end

    // R5: refused flag held over idle cycles, then cleared by an accepted write
    cfg_en_i = 1'b1; cfg_we_i = 1'b1; cfg_addr_i = 4'd7; cfg_mask_i = '1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R5 flag held", 32'(range_err_o), 32'h1);
    pt_i = '1;
    check("R5 refused mask not stored", 32'(sum_o[7]), 32'h0);
    cfg_en_i = 1'b1; cfg_we_i = 1'b1; cfg_addr_i = 4'd7;
    cfg_mask_i = 80'h0000_0000_FFFF_0000_0000;
    @(negedge clk_i);
    cfg_en_i = 1'b0; cfg_we_i = 1'b0;
    check("R4 exact cap clears flag", 32'(range_err_o), 32'h0);
    pt_i = 80'h0000_0000_8000_0000_0000;
    #1;
    check("R4 R2 exact cap stored", 32'(sum_o[7]), 32'h1);

    // R1: reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    pt_i = '1;
    #2;
    check("R1 sum after mid-run reset", 32'(sum_o), 32'h0);
    check("R1 share_err after mid-run reset", 32'(share_err_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 R3 masks cleared", 32'(sum_o), 32'h0);
    finish_run();
  end
endmodule